// File: doc/BRIEF.md
# Adaptive LMS Noise Canceller

This block removes correlated noise from a sampled signal. Each time the input strobe is seen while the block is idle, it takes a raw primary word and a raw reference-noise word. It adds the current reference to the primary to form the corrupted signal. It then runs a 32-tap FIR filter over a delay line of past reference samples to estimate the noise, and reports the corrupted value minus that estimate as the error. The error is the cleaned signal.

Once the error is known, the block adapts every tap weight with the least-mean-squares rule. It then moves the reference history one place along. A single multiplier and accumulator serve both the filter pass and the weight-update pass, one tap per clock. A small controller sequences the passes and raises a busy flag for the whole time the work takes. All arithmetic is fixed point, and the adaptation rate is set by a power-of-two step shift supplied with each sample.

Top module: `lms_canceller`

## Requirements
- R1: While reset is asserted and after it is released, busy, corrupt_vld and err_vld are 0 and both output words are 0. All 32 weights and all 32 delay-line entries start at zero, so the first accepted sample gives an error equal to its corrupted value.
- R2: Only bits 11:0 of each input word are used. The primary is read as an unsigned value 0..4095. The reference is offset binary: bit 11 is inverted and the result is read as a signed 12-bit value, so 0x800 gives 0, 0x000 gives -2048 and 0xFFF gives 2047.
- R3: corrupt_out equals the primary plus the current reference, sign-extended to 16 bits.
- R4: The noise estimate is floor(sum over k of x[k]*w[k] / 2^20). Here x[0] is the current reference, x[k] is the reference from k accepted samples earlier, and w[k] is a 24-bit signed weight carrying 8 fraction bits, so the weighted sum is shifted right by 12 in real terms.
- R5: err_out equals the corrupted value minus the estimate, clamped to the range -32768..32767. Both output words hold their values between valid pulses.
- R6: After the error is formed, each weight becomes clamp24(w[k] + floor(2*e*x[k] / 2^s)). Here e is the clamped error, x[k] is the delay-line value before the shift, s is the step shift, and clamp24 limits the result to -2^23..2^23-1. The delay line then moves one place later and its oldest entry is dropped.
- R7: busy is 1 for exactly 65 cycles, starting in the cycle after the accepting edge. A strobe seen while busy, including in the last update cycle, is ignored. A strobe in the first idle cycle is accepted.
- R8: corrupt_vld and err_vld pulse together for exactly one cycle. They are high in the cycle that follows the 33rd rising edge after the accepting edge.
- R9: The weights are updated one per cycle, from tap 31 down to tap 0.
- R10: The step shift is captured at the accepting edge. Later changes to mu_shift have no effect on that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | Sample strobe; used only while busy is 0 |
| prim_word | input | 16 | Raw primary word; low 12 bits are used |
| ref_word | input | 16 | Raw offset-binary reference-noise word; low 12 bits are used |
| mu_shift | input | 5 | Adaptation step as a right-shift count |
| busy | output | 1 | High while a sample is being processed |
| corrupt_out | output | 16 | Corrupted signal, signed |
| corrupt_vld | output | 1 | One-cycle strobe for corrupt_out |
| err_out | output | 16 | Error, i.e. cleaned signal, signed and saturated |
| err_vld | output | 1 | One-cycle strobe for err_out |

## Verification
The embedded properties assume only that in_vld is sampled at rising edges. They accept any in_vld pattern, including strobes held high across a busy window, and they never assume the data words or mu_shift are stable. The stimulus applies each real strobe for one cycle while the block is idle. It changes the data words and mu_shift straight after acceptance, and it deliberately raises in_vld in the middle of a busy window and in the last update cycle, so that the ignore rule is exercised rather than assumed. Step shifts stay within 0..31. A run with zero shift and full-scale references drives both the weight clamp and the error clamp.

// File: rtl/lms_pkg.sv
`timescale 1ns/1ps
package lms_pkg;
  // Controller phases: idle, filter pass, error forming, weight-update pass
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FIN  = 2'd2,
    ST_UPD  = 2'd3
  } lms_state_e;
endpackage

// File: rtl/lms_prep.sv
`timescale 1ns/1ps
module lms_prep #(
  parameter int WORD_W = 16,
  parameter int SAMP_W = 12,
  parameter int SUM_W  = 14
) (
  input  logic [WORD_W-1:0]        prim_word,
  input  logic [WORD_W-1:0]        ref_word,
  output logic signed [SAMP_W-1:0] ref_samp,
  output logic signed [SUM_W-1:0]  corrupt
);
  logic [SAMP_W-1:0]       prim_low;
  logic [SAMP_W-1:0]       ref_low;
  logic signed [SUM_W-1:0] prim_ext;
  logic signed [SUM_W-1:0] ref_ext;
  logic                    unused_hi;

  always_comb begin
    prim_low = prim_word[SAMP_W-1:0];
    ref_low  = ref_word[SAMP_W-1:0];
    // offset binary to two's complement: flip the top bit
    ref_samp = $signed({~ref_low[SAMP_W-1], ref_low[SAMP_W-2:0]});
    prim_ext = SUM_W'(prim_low);
    ref_ext  = SUM_W'(ref_samp);
    corrupt  = prim_ext + ref_ext;
  end

  assign unused_hi = ^{prim_word[WORD_W-1:SAMP_W], ref_word[WORD_W-1:SAMP_W]};
endmodule

// File: rtl/lms_ctrl.sv
`timescale 1ns/1ps
module lms_ctrl
  import lms_pkg::*;
#(
  parameter int TAPS  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  output logic             accept,
  output logic             busy,
  output logic             acc_clr,
  output logic             acc_en,
  output logic             fin,
  output logic             upd_en,
  output logic             out_vld,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TAPS - 1);

  lms_state_e       state_q, state_nxt;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             vld_q, vld_nxt;

  always_comb begin
    state_nxt = state_q;
    idx_nxt   = idx_q;
    case (state_q)
      ST_IDLE: begin
        if (in_vld) begin
          state_nxt = ST_ACC;
          idx_nxt   = '0;
        end
      end
      ST_ACC: begin
        if (idx_q == LAST) state_nxt = ST_FIN;
        else               idx_nxt   = idx_q + 1'b1;
      end
      ST_FIN: begin
        state_nxt = ST_UPD;
        idx_nxt   = LAST;
      end
      ST_UPD: begin
        if (idx_q == '0) state_nxt = ST_IDLE;
        else             idx_nxt   = idx_q - 1'b1;
      end
      default: state_nxt = ST_IDLE;
    endcase
    vld_nxt = (state_q == ST_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_nxt;
      idx_q   <= idx_nxt;
      vld_q   <= vld_nxt;
    end
  end

  assign accept  = (state_q == ST_IDLE) && in_vld;
  assign busy    = (state_q != ST_IDLE);
  assign acc_clr = accept;
  assign acc_en  = (state_q == ST_ACC);
  assign fin     = (state_q == ST_FIN);
  assign upd_en  = (state_q == ST_UPD);
  assign out_vld = vld_q;
  assign idx     = idx_q;

  // R7: an accepted strobe starts a busy window
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !busy) |=> busy);

  // R7: a strobe during the busy window does not shorten or restart it
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_vld && !(state_q == ST_UPD && idx_q == '0)) |=> busy);

  // R8: valid is a single-cycle pulse
  p_vld_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

  // R9: update pass walks taps downward, one per cycle
  p_upd_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UPD && idx_q != '0) |=> (state_q == ST_UPD && idx_q == $past(idx_q) - 1'b1));
endmodule

// File: rtl/lms_taps.sv
`timescale 1ns/1ps
module lms_taps #(
  parameter int TAPS   = 32,
  parameter int SAMP_W = 12,
  parameter int COEF_W = 24,
  parameter int IDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic signed [SAMP_W-1:0] load_samp,
  input  logic                     upd_en,
  input  logic [IDX_W-1:0]         sel,
  input  logic signed [COEF_W-1:0] coef_new,
  output logic signed [SAMP_W-1:0] samp_rd,
  output logic signed [COEF_W-1:0] coef_rd
);
  logic signed [SAMP_W-1:0] line_q  [TAPS];
  logic signed [SAMP_W-1:0] line_in [TAPS];
  logic signed [COEF_W-1:0] coef_q  [TAPS];
  logic [TAPS-1:0]          coef_we;
  logic [TAPS-1:0]          line_we;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign coef_we[g] = upd_en && (sel == IDX_W'(g));
    if (g == 0) begin : g_head
      assign line_we[g] = load_en;
      assign line_in[g] = load_samp;
    end else begin : g_body
      // entry g takes its neighbour's value right after that neighbour's weight update
      assign line_we[g] = upd_en && (sel == IDX_W'(g - 1));
      assign line_in[g] = line_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        line_q[k] <= '0;
        coef_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < TAPS; k++) begin
        if (coef_we[k]) coef_q[k] <= coef_new;
        if (line_we[k]) line_q[k] <= line_in[k];
      end
    end
  end

  assign samp_rd = line_q[sel];
  assign coef_rd = coef_q[sel];
endmodule

// File: rtl/lms_mac.sv
`timescale 1ns/1ps
module lms_mac #(
  parameter int SAMP_W = 12,
  parameter int COEF_W = 24,
  parameter int OUT_W  = 16,
  parameter int SUM_W  = 14,
  parameter int MU_W   = 5,
  parameter int ACC_W  = 41,
  parameter int EST_SH = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_clr,
  input  logic                     acc_en,
  input  logic                     fin,
  input  logic                     upd_en,
  input  logic signed [SAMP_W-1:0] samp_rd,
  input  logic signed [COEF_W-1:0] coef_rd,
  input  logic signed [SUM_W-1:0]  corrupt_q,
  input  logic [MU_W-1:0]          mu_q,
  output logic signed [COEF_W-1:0] coef_new,
  output logic signed [OUT_W-1:0]  err_q
);
  localparam int PROD_W = SAMP_W + COEF_W;
  localparam int DLT_W  = PROD_W + 1;
  localparam int WS_W   = PROD_W + 2;

  logic signed [COEF_W-1:0] mul_b;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc_q, acc_nxt;
  logic signed [ACC_W-1:0]  est;
  logic signed [ACC_W:0]    diff;
  logic signed [OUT_W-1:0]  err_sat, err_nxt;
  logic signed [DLT_W-1:0]  dbl, dlt;
  logic signed [WS_W-1:0]   wsum;

  always_comb begin
    // one multiplier: weight operand while filtering, error operand while adapting
    mul_b = upd_en ? COEF_W'(err_q) : coef_rd;
    prod  = PROD_W'(samp_rd) * PROD_W'(mul_b);

    acc_nxt = acc_q;
    if (acc_clr)     acc_nxt = '0;
    else if (acc_en) acc_nxt = acc_q + ACC_W'(prod);

    est  = acc_q >>> EST_SH;
    diff = (ACC_W+1)'(corrupt_q) - (ACC_W+1)'(est);
    if (diff[ACC_W:OUT_W-1] == {(ACC_W-OUT_W+2){diff[ACC_W]}})
      err_sat = diff[OUT_W-1:0];
    else
      err_sat = diff[ACC_W] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    err_nxt = fin ? err_sat : err_q;

    dbl  = $signed({prod, 1'b0});
    dlt  = dbl >>> mu_q;
    wsum = WS_W'(coef_rd) + WS_W'(dlt);
    if (wsum[WS_W-1:COEF_W-1] == {(WS_W-COEF_W+1){wsum[WS_W-1]}})
      coef_new = wsum[COEF_W-1:0];
    else
      coef_new = wsum[WS_W-1] ? {1'b1, {(COEF_W-1){1'b0}}} : {1'b0, {(COEF_W-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      err_q <= '0;
    end else begin
      acc_q <= acc_nxt;
      err_q <= err_nxt;
    end
  end
endmodule

// File: rtl/lms_canceller.sv
`timescale 1ns/1ps
module lms_canceller #(
  parameter int WORD_W = 16,
  parameter int SAMP_W = 12,
  parameter int COEF_W = 24,
  parameter int FRAC_W = 8,
  parameter int TAPS   = 32,
  parameter int OUT_W  = 16,
  parameter int MU_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] prim_word,
  input  logic [WORD_W-1:0] ref_word,
  input  logic [MU_W-1:0]   mu_shift,
  output logic              busy,
  output logic [OUT_W-1:0]  corrupt_out,
  output logic              corrupt_vld,
  output logic [OUT_W-1:0]  err_out,
  output logic              err_vld
);
  localparam int IDX_W  = $clog2(TAPS);
  localparam int SUM_W  = SAMP_W + 2;
  localparam int ACC_W  = SAMP_W + COEF_W + IDX_W;
  localparam int EST_SH = SAMP_W + FRAC_W;

  logic [1:0]               rst_pipe;
  logic                     rst_core;
  logic                     accept, acc_clr, acc_en, fin, upd_en, out_vld;
  logic [IDX_W-1:0]         idx;
  logic signed [SAMP_W-1:0] ref_samp, samp_rd;
  logic signed [SUM_W-1:0]  corrupt_c, corrupt_q, corrupt_nxt;
  logic [MU_W-1:0]          mu_q, mu_nxt;
  logic signed [COEF_W-1:0] coef_rd, coef_new;
  logic signed [OUT_W-1:0]  err_q;
  logic [OUT_W-1:0]         cor_out_q, cor_out_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core = rst_pipe[1];

  lms_prep #(.WORD_W(WORD_W), .SAMP_W(SAMP_W), .SUM_W(SUM_W)) u_prep (
    .prim_word (prim_word),
    .ref_word  (ref_word),
    .ref_samp  (ref_samp),
    .corrupt   (corrupt_c)
  );

  lms_ctrl #(.TAPS(TAPS), .IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core),
    .in_vld  (in_vld),
    .accept  (accept),
    .busy    (busy),
    .acc_clr (acc_clr),
    .acc_en  (acc_en),
    .fin     (fin),
    .upd_en  (upd_en),
    .out_vld (out_vld),
    .idx     (idx)
  );

  lms_taps #(.TAPS(TAPS), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_taps (
    .clk       (clk),
    .rst_n     (rst_core),
    .load_en   (accept),
    .load_samp (ref_samp),
    .upd_en    (upd_en),
    .sel       (idx),
    .coef_new  (coef_new),
    .samp_rd   (samp_rd),
    .coef_rd   (coef_rd)
  );

  lms_mac #(
    .SAMP_W(SAMP_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .SUM_W(SUM_W),
    .MU_W(MU_W), .ACC_W(ACC_W), .EST_SH(EST_SH)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_core),
    .acc_clr   (acc_clr),
    .acc_en    (acc_en),
    .fin       (fin),
    .upd_en    (upd_en),
    .samp_rd   (samp_rd),
    .coef_rd   (coef_rd),
    .corrupt_q (corrupt_q),
    .mu_q      (mu_q),
    .coef_new  (coef_new),
    .err_q     (err_q)
  );

  always_comb begin
    corrupt_nxt = accept ? corrupt_c : corrupt_q;
    mu_nxt      = accept ? mu_shift  : mu_q;
    cor_out_nxt = fin ? OUT_W'(corrupt_q) : cor_out_q;
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      corrupt_q <= '0;
      mu_q      <= '0;
      cor_out_q <= '0;
    end else begin
      corrupt_q <= corrupt_nxt;
      mu_q      <= mu_nxt;
      cor_out_q <= cor_out_nxt;
    end
  end

  assign corrupt_out = cor_out_q;
  assign err_out     = err_q;
  assign corrupt_vld = out_vld;
  assign err_vld     = out_vld;

  // R5: error word only moves when its strobe is raised
  p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_core)
    !err_vld |-> $stable(err_out));

  // R3: corrupted word only moves when its strobe is raised
  p_corrupt_hold_r3: assert property (@(posedge clk) disable iff (!rst_core)
    !corrupt_vld |-> $stable(corrupt_out));
endmodule

// File: tb/tb_lms_canceller.sv
`timescale 1ns/1ps
module tb_lms_canceller;
  localparam int TAPS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [15:0] prim_word = '0;
  logic [15:0] ref_word = '0;
  logic [4:0]  mu_shift = '0;
  logic        busy, corrupt_vld, err_vld;
  logic [15:0] corrupt_out, err_out;

  lms_canceller dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_vld      (in_vld),
    .prim_word   (prim_word),
    .ref_word    (ref_word),
    .mu_shift    (mu_shift),
    .busy        (busy),
    .corrupt_out (corrupt_out),
    .corrupt_vld (corrupt_vld),
    .err_out     (err_out),
    .err_vld     (err_vld)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  int unsigned seed = 32'h1234_5678;
  longint      mw [TAPS];
  longint      mx [TAPS];
  longint      q_c [$];
  longint      q_e [$];
  int          q_t [$];
  longint      mc, me;
  int          mt;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint clampv(input longint v, input int w);
    longint hi, lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int unsigned nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // reference model of one accepted sample, from the requirements
  task automatic model(input int p, input int r, input int mu, input int t0);
    longint pv, rv, c, acc, est, e, d;
    pv = longint'(p & 'hFFF);
    rv = longint'((r & 'hFFF) ^ 'h800);
    if (rv >= 2048) rv = rv - 4096;
    c = pv + rv;
    mx[0] = rv;
    acc = 0;
    for (int k = 0; k < TAPS; k++) acc = acc + mx[k] * mw[k];
    est = acc >>> 20;
    e = clampv(c - est, 16);
    for (int k = TAPS - 1; k >= 0; k--) begin
      d = (2 * e * mx[k]) >>> mu;
      mw[k] = clampv(mw[k] + d, 24);
      if (k < TAPS - 1) mx[k+1] = mx[k];
    end
    q_c.push_back(c);
    q_e.push_back(e);
    q_t.push_back(t0);
  endtask

  // driver: one accepted sample, optional strobes while busy
  task automatic send(input int p, input int r, input int mu, input bit spur);
    int bcnt;
    while (busy) @(negedge clk);
    prim_word = p[15:0];
    ref_word  = r[15:0];
    mu_shift  = mu[4:0];
    in_vld    = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    model(p, r, mu, cyc);
    chk("R7 busy after accept", longint'(busy), 1);
    // R10: disturb inputs after acceptance
    mu_shift  = ~mu[4:0];
    prim_word = ~prim_word;
    ref_word  = ref_word ^ 16'h0A5A;
    bcnt = 0;
    while (busy) begin
      bcnt++;
      in_vld = spur && (bcnt == 5 || bcnt == 40 || bcnt == 65);
      @(negedge clk);
    end
    in_vld = 1'b0;
    chk("R7 busy length", bcnt, 65);
  endtask

  // monitor: pop expected results as the design reports them
  always @(negedge clk) begin
    if (rst_n && !done && err_vld) begin
      chk("R8 valid pair", longint'(corrupt_vld), 1);
      if (q_c.size() == 0) begin
        chk("R7 unexpected result", 1, 0);
      end else begin
        mc = q_c.pop_front();
        me = q_e.pop_front();
        mt = q_t.pop_front();
        chk("R2 R3 corrupted", longint'($signed(corrupt_out)), mc);
        chk("R4 R5 R6 R9 R10 error", longint'($signed(err_out)), me);
        chk("R8 latency", cyc - mt, 33);
      end
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin
      mw[k] = 0;
      mx[k] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", longint'(busy), 0);
    chk("R1 valid in reset", longint'(err_vld | corrupt_vld), 0);
    chk("R1 error word in reset", longint'(err_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", longint'(busy), 0);
    chk("R1 corrupted word after reset", longint'(corrupt_out), 0);
    chk("R1 valid after reset", longint'(err_vld | corrupt_vld), 0);

    // directed conditioning cases
    send('hF123, 'hA800, 4, 1'b0);
    send('h0FFF, 'h0000, 4, 1'b0);
    send('h0000, 'h0FFF, 4, 1'b1);
    send('h7800, 'hF7FF, 3, 1'b0);

    // random traffic with ignored strobes
    for (int i = 0; i < 100; i++) begin
      int p, r, mu;
      p  = int'(nxt() >> 8);
      r  = int'(nxt() >> 8);
      mu = 4 + int'((nxt() >> 4) % 6);
      send(p, r, mu, (i % 7) == 0);
    end

    // full-scale reference with zero step shift: clamps on weights and error
    for (int i = 0; i < 30; i++) begin
      send('h0FFF, (i % 3 == 0) ? 'h0000 : 'h0FFF, 0, (i % 5) == 0);
    end

    // back to modest step after saturation
    for (int i = 0; i < 10; i++) begin
      send(int'(nxt() >> 12), int'(nxt() >> 12), 9, 1'b0);
    end

    repeat (60) @(negedge clk);
    chk("R8 all results reported", q_c.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule